// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel Pair

This block holds a set of independent DMA channels (two by default). Each channel copies 32-bit words between system memory and device-local memory. In direct mode, software loads a system address, a device address and a byte count, then starts the channel. In chained mode, the channel reads a linked list of four-word descriptors from system memory. It transfers each descriptor's payload, then follows the descriptor's link word until it finds one that carries the end-of-list flag. The link word also carries the per-descriptor interrupt enable. Its low four bits are free for flags because descriptors are 16-byte aligned.

Software drives each channel through a 12-bit register window. Per channel, the window holds a system-address, device-address, byte-count and link register, a mode register and a command/status register. The done flags in the command/status register clear when software writes a one to them. An abort stops the channel after the memory access in flight and raises no interrupt. Software detects that the abort has finished when the enable bit reads back zero. Each channel has its own memory-request port, which uses a request/acknowledge handshake. One interrupt line combines the enabled done flags of all channels.

Top module: `dma_chain_top`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and no channel raises `memReq`.
- R2: Channel c places its system-address, device-address, byte-count and link registers at 0xE40+0x10*c, +4, +8 and +0xC. Its mode register is at 0xE80+4*c and its command/status register at 0xE90+4*c. Slots of channels that are not built read 0, and writes to them change nothing.
- R3: Channel start is a command/status write with bit 0 (enable) and bit 1 (start) both set. In direct mode (mode bit 0 = 0), the channel then moves byte-count/4 words and sets transfer done (status bit 3), while enable stays 1. With mode bit 2 = 0, data is read from the system address (`memSpace`=0) and written to the device address (`memSpace`=1). With mode bit 2 = 1, the direction is reversed.
- R4: In chained mode (mode bit 0 = 1), the channel reads descriptors from system memory at the link address with its low 4 bits cleared. Each descriptor holds four words: system address, device address, byte count, link. After each descriptor the channel sets descriptor done (status bit 4). If the new link has bit 1 set, the channel then sets transfer done and stops; otherwise it fetches the next descriptor.
- R5: A chained-mode start whose link register already has bit 1 set issues no memory request and sets transfer done at the start edge.
- R6: A byte count below 4 moves no data. In chained mode the descriptor still sets descriptor done and the chain continues. In direct mode transfer done is set with no memory request.
- R7: Writing a one to status bit 3 or bit 4 clears that flag, and writing a zero leaves it. When hardware sets a flag in the same cycle as the clear, the set wins.
- R8: A write with status bit 2 set while the channel is busy completes the access in flight. The channel then issues no further request and clears enable, without setting transfer done or raising `irq`.
- R9: `irq` is the OR over channels of (transfer done AND mode bit 1) and (descriptor done AND bit 2 of the last fetched link word).
- R10: Bit 3 of the link register reads back mode bit 2, and software cannot write it.
- R11: While a channel is busy, writes to its address, count, link and mode registers and to its enable bit have no effect.
- R12: Once `memReq` is raised, it stays high with stable address and write flag until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| memReq | output | NCH | Per-channel memory request |
| memWe | output | NCH | Per-channel write (1) or read (0) |
| memSpace | output | NCH | Per-channel target: 0 system, 1 device |
| memAddr | output | 32*NCH | Per-channel byte address |
| memWdata | output | 32*NCH | Per-channel write data |
| memAck | input | NCH | Per-channel access completion |
| memRdata | input | 32*NCH | Per-channel read data, valid with memAck |
| irq | output | 1 | Combined interrupt |

## Verification
The clearing of a done flag by software and the setting of the same flag by the channel can fall in the same cycle. The bench provokes this with a one-word, end-of-list descriptor. It watches for the acknowledge of the payload write and drives the write-one-to-clear of descriptor done into the following cycle, which is exactly the cycle in which the channel sets that flag. The bench judges the outcome by reading the status afterwards: descriptor done must still be set, and a later clear on an idle channel must remove it.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam logic [11:0] CH_BLK_BASE = 12'hE40;
  localparam logic [11:0] MODE_BASE   = 12'hE80;
  localparam logic [11:0] CSR_BASE    = 12'hE90;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addrSel_e;

  typedef struct packed {
    logic       ldWord;
    logic [1:0] wordSel;
    addrSel_e   addrSel;
    logic       latchData;
    logic       step;
    logic       setDd;
    logic       setTd;
    logic       abortDone;
  } dmaStb_t;

  typedef struct packed {
    logic start;
    logic chainMode;
    logic endChain;
    logic wordsZero;
    logic abortPend;
  } dmaStat_t;
endpackage

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dmaStat_t stat,
  input  logic     memAck,
  output dmaStb_t  stb,
  output logic     memReq,
  output logic     memWe,
  output logic     busy
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR} state_e;
  state_e state, stateN;
  logic [1:0] idx, idxN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      state <= stateN;
      idx   <= idxN;
    end
  end

  always_comb begin
    stb         = '0;
    stb.wordSel = idx;
    stb.addrSel = SEL_DESC;
    memReq      = 1'b0;
    memWe       = 1'b0;
    stateN      = state;
    idxN        = idx;
    case (state)
      S_IDLE: begin
        if (stat.start) begin
          if (stat.chainMode) begin
            if (stat.endChain) stb.setTd = 1'b1;
            else begin
              stateN = S_FETCH;
              idxN   = '0;
            end
          end else if (stat.wordsZero) stb.setTd = 1'b1;
          else stateN = S_RD;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (stat.abortPend) begin
            stb.abortDone = 1'b1;
            stateN = S_IDLE;
          end else begin
            stb.ldWord = 1'b1;
            if (idx == 2'd3) stateN = S_CHECK;
            else idxN = idx + 2'd1;
          end
        end
      end
      S_CHECK: begin
        if (stat.abortPend) begin
          stb.abortDone = 1'b1;
          stateN = S_IDLE;
        end else if (!stat.wordsZero) stateN = S_RD;
        else if (stat.chainMode) begin
          stb.setDd = 1'b1;
          if (stat.endChain) begin
            stb.setTd = 1'b1;
            stateN = S_IDLE;
          end else begin
            stateN = S_FETCH;
            idxN   = '0;
          end
        end else begin
          stb.setTd = 1'b1;
          stateN = S_IDLE;
        end
      end
      S_RD: begin
        memReq      = 1'b1;
        stb.addrSel = SEL_SRC;
        if (memAck) begin
          stb.latchData = 1'b1;
          if (stat.abortPend) begin
            stb.abortDone = 1'b1;
            stateN = S_IDLE;
          end else stateN = S_WR;
        end
      end
      S_WR: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        stb.addrSel = SEL_DST;
        if (memAck) begin
          stb.step = 1'b1;
          if (stat.abortPend) begin
            stb.abortDone = 1'b1;
            stateN = S_IDLE;
          end else stateN = S_CHECK;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/dma_chain_path.sv
module dma_chain_path
  import dma_chain_pkg::*;
#(
  parameter int CH = 0,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic [11:0]   regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] rdData,
  input  logic          busy,
  input  dmaStb_t       stb,
  output dmaStat_t      stat,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic          memSpace,
  output logic [DW-1:0] memWdata,
  output logic          deOut,
  output logic          tdOut,
  output logic          ddOut,
  output logic          irqOut
);
  localparam logic [11:0] BLK  = CH_BLK_BASE + 12'(CH * 16);
  localparam logic [11:0] MODA = MODE_BASE + 12'(CH * 4);
  localparam logic [11:0] CSRA = CSR_BASE + 12'(CH * 4);

  logic [DW-1:0] sysA, devA, cnt, link, dataBuf;
  logic [2:0]    mode;
  logic          de, td, dd, ddIe, abortPend;
  logic          hitSys, hitDev, hitCnt, hitLink, hitMode, hitCsr, cfgWr, csrWr, dir;

  assign hitSys  = regAddr == BLK;
  assign hitDev  = regAddr == BLK + 12'd4;
  assign hitCnt  = regAddr == BLK + 12'd8;
  assign hitLink = regAddr == BLK + 12'd12;
  assign hitMode = regAddr == MODA;
  assign hitCsr  = regAddr == CSRA;
  assign cfgWr   = regWr && !busy;
  assign csrWr   = regWr && hitCsr;
  assign dir     = mode[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysA <= '0; devA <= '0; cnt <= '0; link <= '0; dataBuf <= '0;
      mode <= '0; de <= 1'b0; td <= 1'b0; dd <= 1'b0; ddIe <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      if (stb.ldWord) begin
        case (stb.wordSel)
          2'd0: sysA <= memRdata;
          2'd1: devA <= memRdata;
          2'd2: cnt  <= memRdata;
          default: begin
            link <= memRdata;
            ddIe <= memRdata[2];
          end
        endcase
      end else if (stb.step) begin
        sysA <= sysA + DW'(4);
        devA <= devA + DW'(4);
        cnt  <= cnt - DW'(4);
      end else if (cfgWr) begin
        if (hitSys)  sysA <= regWdata;
        if (hitDev)  devA <= regWdata;
        if (hitCnt)  cnt  <= regWdata;
        if (hitLink) link <= regWdata;
      end
      if (cfgWr && hitMode) mode <= regWdata[2:0];
      if (stb.latchData) dataBuf <= memRdata;
      if (stb.abortDone) de <= 1'b0;
      else if (csrWr && !busy && !regWdata[2]) de <= regWdata[0];
      if (stb.setTd) td <= 1'b1;
      else if (csrWr && regWdata[3]) td <= 1'b0;
      if (stb.setDd) dd <= 1'b1;
      else if (csrWr && regWdata[4]) dd <= 1'b0;
      if (stb.abortDone) abortPend <= 1'b0;
      else if (csrWr && regWdata[2] && busy) abortPend <= 1'b1;
    end
  end

  assign stat.start     = csrWr && !busy && regWdata[0] && regWdata[1] && !regWdata[2];
  assign stat.chainMode = mode[0];
  assign stat.endChain  = link[1];
  assign stat.wordsZero = (cnt[DW-1:2] == '0);
  assign stat.abortPend = abortPend;

  always_comb begin
    case (stb.addrSel)
      SEL_SRC: begin memAddr = dir ? devA : sysA; memSpace = dir;  end
      SEL_DST: begin memAddr = dir ? sysA : devA; memSpace = !dir; end
      default: begin memAddr = {link[DW-1:4], stb.wordSel, 2'b00}; memSpace = 1'b0; end
    endcase
  end
  assign memWdata = dataBuf;

  always_comb begin
    rdData = '0;
    if (hitSys)  rdData = sysA;
    if (hitDev)  rdData = devA;
    if (hitCnt)  rdData = cnt;
    if (hitLink) rdData = {link[DW-1:4], dir, link[2:0]};
    if (hitMode) rdData = {{(DW-3){1'b0}}, mode};
    if (hitCsr)  rdData = {{(DW-5){1'b0}}, dd, td, 2'b00, de};
  end

  logic unusedBits;
  assign unusedBits = ^{regWdata[DW-1:5], link[3]};

  assign deOut  = de;
  assign tdOut  = td;
  assign ddOut  = dd;
  assign irqOut = (td && mode[1]) || (dd && ddIe);
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
  import dma_chain_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [11:0]       regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  output logic [NCH-1:0]    memReq,
  output logic [NCH-1:0]    memWe,
  output logic [NCH-1:0]    memSpace,
  output logic [NCH*DW-1:0] memAddr,
  output logic [NCH*DW-1:0] memWdata,
  input  logic [NCH-1:0]    memAck,
  input  logic [NCH*DW-1:0] memRdata,
  output logic              irq
);
  logic [DW-1:0]  chRd [NCH];
  logic [NCH-1:0] busyVec, deVec, tdVec, ddVec, irqVec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmaStb_t  stb;
    dmaStat_t stat;
    dma_chain_ctrl u_ctrl (
      .clk(clk), .rstN(rstN), .stat(stat), .memAck(memAck[c]), .stb(stb),
      .memReq(memReq[c]), .memWe(memWe[c]), .busy(busyVec[c])
    );
    dma_chain_path #(.CH(c), .DW(DW)) u_path (
      .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
      .regWdata(regWdata), .rdData(chRd[c]), .busy(busyVec[c]), .stb(stb),
      .stat(stat), .memRdata(memRdata[c*DW +: DW]),
      .memAddr(memAddr[c*DW +: DW]), .memSpace(memSpace[c]),
      .memWdata(memWdata[c*DW +: DW]), .deOut(deVec[c]), .tdOut(tdVec[c]),
      .ddOut(ddVec[c]), .irqOut(irqVec[c])
    );
  end

  always_comb begin
    regRdata = '0;
    for (int c = 0; c < NCH; c++) regRdata = regRdata | chRd[c];
  end

  assign irq = |irqVec;
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    memReq,
  input logic [NCH-1:0]    memWe,
  input logic [NCH-1:0]    memAck,
  input logic [NCH*DW-1:0] memAddr,
  input logic              irq,
  input logic [NCH-1:0]    busyVec,
  input logic [NCH-1:0]    deVec,
  input logic [NCH-1:0]    tdVec,
  input logic [NCH-1:0]    ddVec
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      memReq[c] && !memAck[c] |=> memReq[c] && $stable(memAddr[c*DW +: DW]) && $stable(memWe[c]));
    // R3
    td_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(tdVec[c]) |-> !busyVec[c]);
    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(deVec[c]) |-> !$rose(tdVec[c]));
  end
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((tdVec | ddVec) != '0));
endmodule

bind dma_chain_top dma_chain_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .irq(irq), .busyVec(busyVec), .deVec(deVec),
  .tdVec(tdVec), .ddVec(ddVec)
);

// File: tb/sim_dma_chain_top.sv
`timescale 1ns/1ps
module sim_dma_chain_top;
  localparam int NCH = 2;
  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [NCH-1:0] memReq, memWe, memSpace, memAck;
  logic [NCH*32-1:0] memAddr, memWdata, memRdata;
  logic irq;
  logic [31:0] sysMem [256];
  logic [31:0] devMem [256];
  int total = 0, bad = 0, hsCount = 0, holdErr = 0;
  logic [NCH-1:0] prevWait = '0;
  logic [31:0] prevAddr [NCH];

  always #2.5 clk = ~clk;

  dma_chain_top #(.NCH(NCH)) u0 (.*);

  // memory responder: ack on the second cycle of each request
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] a;
      a = memAddr[c*32 +: 32];
      if (!rstN) memAck[c] <= 1'b0;
      else begin
        if (memReq[c] && memAck[c]) begin
          hsCount <= hsCount + 1;
          if (memWe[c]) begin
            if (memSpace[c]) devMem[a[9:2]] <= memWdata[c*32 +: 32];
            else sysMem[a[9:2]] <= memWdata[c*32 +: 32];
          end
        end
        memAck[c] <= memReq[c] && !memAck[c];
        memRdata[c*32 +: 32] <= memSpace[c] ? devMem[a[9:2]] : sysMem[a[9:2]];
      end
    end
  end

  // R12 monitor
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (prevWait[c] && (!memReq[c] || memAddr[c*32 +: 32] != prevAddr[c])) holdErr++;
      prevWait[c] = memReq[c] && !memAck[c];
      prevAddr[c] = memAddr[c*32 +: 32];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdata;
  endtask

  task automatic waitCsr(input logic [11:0] a, input int bitN, input logic val);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(a, d);
      if (d[bitN] == val) return;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'hE40, d); chk("R1 sys addr", d, 0);
    rd(12'hE4C, d); chk("R1 link", d, 0);
    rd(12'hE80, d); chk("R1 mode", d, 0);
    rd(12'hE90, d); chk("R1 csr", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 memReq", {30'b0, memReq}, 0);
  endtask

  task automatic t_offsets;
    logic [31:0] d;
    wr(12'hE50, 32'h1111_0000);
    rd(12'hE50, d); chk("R2 ch1 sys addr", d, 32'h1111_0000);
    rd(12'hE40, d); chk("R2 ch0 untouched", d, 0);
    wr(12'hE60, 32'hFFFF);
    rd(12'hE60, d); chk("R2 reserved slot", d, 0);
    wr(12'hE84, 32'h2);
    rd(12'hE84, d); chk("R2 ch1 mode", d, 2);
    rd(12'hE80, d); chk("R2 ch0 mode", d, 0);
    wr(12'hE84, 0);
  endtask

  task automatic t_direct;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) sysMem[16+i] = 32'hA000 + i;
    wr(12'hE80, 0); wr(12'hE40, 32'h40); wr(12'hE44, 32'h80); wr(12'hE48, 12);
    wr(12'hE90, 3);
    waitCsr(12'hE90, 3, 1'b1);
    for (int i = 0; i < 3; i++) chk("R3 sys to dev word", devMem[32+i], 32'hA000 + i);
    rd(12'hE90, d); chk("R3 status after done", d, 32'h9);
    rd(12'hE40, d); chk("R3 sys addr advanced", d, 32'h4C);
    wr(12'hE90, 32'h9);
    rd(12'hE90, d); chk("R7 done cleared", d, 32'h1);
  endtask

  task automatic t_reverse;
    logic [31:0] d;
    devMem[36] = 32'hBEEF0001; devMem[37] = 32'hBEEF0002;
    wr(12'hE80, 4);
    wr(12'hE4C, 0);
    rd(12'hE4C, d); chk("R10 link bit3 shows direction", d, 32'h8);
    wr(12'hE40, 32'hA0); wr(12'hE44, 32'h90); wr(12'hE48, 8);
    wr(12'hE90, 3);
    waitCsr(12'hE90, 3, 1'b1);
    chk("R3 dev to sys word0", sysMem[40], 32'hBEEF0001);
    chk("R3 dev to sys word1", sysMem[41], 32'hBEEF0002);
    wr(12'hE90, 32'h9);
    wr(12'hE80, 0);
    wr(12'hE4C, 32'h8);
    rd(12'hE4C, d); chk("R10 link bit3 not writable", d, 0);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    sysMem[64] = 32'h200; sysMem[65] = 32'h300; sysMem[66] = 8; sysMem[67] = 32'h140;
    sysMem[80] = 32'h240; sysMem[81] = 32'h340; sysMem[82] = 4; sysMem[83] = 32'h2;
    sysMem[128] = 32'hC0DE0000; sysMem[129] = 32'hC0DE0001; sysMem[144] = 32'hC0DE0002;
    wr(12'hE80, 1); wr(12'hE4C, 32'h100); wr(12'hE90, 3);
    waitCsr(12'hE90, 3, 1'b1);
    chk("R4 desc0 word0", devMem[192], 32'hC0DE0000);
    chk("R4 desc0 word1", devMem[193], 32'hC0DE0001);
    chk("R4 desc1 word0", devMem[208], 32'hC0DE0002);
    rd(12'hE90, d); chk("R4 status", d, 32'h19);
    rd(12'hE4C, d); chk("R4 link holds last next", d, 32'h2);
    wr(12'hE90, 32'h19);
  endtask

  task automatic t_ecStart;
    logic [31:0] d;
    int h0;
    wr(12'hE80, 1); wr(12'hE4C, 32'h2);
    h0 = hsCount;
    wr(12'hE90, 3);
    rd(12'hE90, d); chk("R5 done at once", d, 32'h9);
    chk("R5 no memory access", hsCount - h0, 0);
    wr(12'hE90, 32'h9);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    int h0;
    sysMem[96]  = 32'h200; sysMem[97]  = 32'h380; sysMem[98]  = 0; sysMem[99]  = 32'h1C0;
    sysMem[112] = 32'h250; sysMem[113] = 32'h390; sysMem[114] = 4; sysMem[115] = 32'h2;
    sysMem[148] = 32'h5A5A5A5A; devMem[224] = 32'h77;
    wr(12'hE80, 1); wr(12'hE4C, 32'h180);
    h0 = hsCount;
    wr(12'hE90, 3);
    waitCsr(12'hE90, 3, 1'b1);
    chk("R6 handshakes for empty plus one-word desc", hsCount - h0, 10);
    chk("R6 empty desc wrote nothing", devMem[224], 32'h77);
    chk("R6 chain continued", devMem[228], 32'h5A5A5A5A);
    rd(12'hE90, d); chk("R6 status", d, 32'h19);
    wr(12'hE90, 32'h19);
    wr(12'hE80, 0); wr(12'hE48, 0);
    h0 = hsCount;
    wr(12'hE90, 3);
    rd(12'hE90, d); chk("R6 direct empty done", d, 32'h9);
    chk("R6 direct empty no access", hsCount - h0, 0);
    wr(12'hE90, 32'h9);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    sysMem[120] = 32'h40; sysMem[121] = 32'h3F0; sysMem[122] = 4; sysMem[123] = 32'h2;
    wr(12'hE80, 1); wr(12'hE4C, 32'h1E0); wr(12'hE90, 3);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (memReq[0] && memWe[0] && memAck[0]) break;
    end
    @(negedge clk);
    regWr = 1'b1; regAddr = 12'hE90; regWdata = 32'h11;
    @(negedge clk);
    regWr = 1'b0;
    rd(12'hE90, d); chk("R7 set wins over clear", d, 32'h19);
    wr(12'hE90, 32'h19);
    rd(12'hE90, d); chk("R7 clear when idle", d, 32'h1);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    int h0;
    wr(12'hE80, 2); wr(12'hE40, 32'h40); wr(12'hE44, 32'h200); wr(12'hE48, 64);
    wr(12'hE90, 3);
    repeat (6) @(negedge clk);
    wr(12'hE90, 32'h4);
    waitCsr(12'hE90, 0, 1'b0);
    h0 = hsCount;
    repeat (10) @(negedge clk);
    chk("R8 no access after abort", hsCount - h0, 0);
    rd(12'hE90, d); chk("R8 status after abort", d, 0);
    chk("R8 no irq", {31'b0, irq}, 0);
    rd(12'hE48, d); chk("R8 count left", {31'b0, d != 0}, 1);
    wr(12'hE80, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(12'hE84, 2); wr(12'hE58, 0); wr(12'hE94, 3);
    @(negedge clk);
    chk("R9 irq from ch1 done", {31'b0, irq}, 1);
    wr(12'hE94, 32'h9);
    @(negedge clk);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    sysMem[123] = 32'h6;
    wr(12'hE80, 1); wr(12'hE4C, 32'h1E0); wr(12'hE90, 3);
    waitCsr(12'hE90, 3, 1'b1);
    chk("R9 irq from desc done", {31'b0, irq}, 1);
    wr(12'hE90, 32'h11);
    @(negedge clk);
    chk("R9 done without enable gives no irq", {31'b0, irq}, 0);
    wr(12'hE90, 32'h9);
  endtask

  task automatic t_busyWr;
    logic [31:0] d;
    wr(12'hE80, 0); wr(12'hE40, 32'h40); wr(12'hE44, 32'h200); wr(12'hE48, 16);
    wr(12'hE90, 3);
    wr(12'hE40, 32'hFFF0);
    wr(12'hE80, 4);
    wr(12'hE90, 0);
    waitCsr(12'hE90, 3, 1'b1);
    rd(12'hE40, d); chk("R11 sys addr write ignored", d, 32'h50);
    rd(12'hE80, d); chk("R11 mode write ignored", d, 0);
    rd(12'hE90, d); chk("R11 enable write ignored", d, 32'h9);
    wr(12'hE90, 32'h9);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin sysMem[i] = '0; devMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_offsets();
    t_direct();
    t_reverse();
    t_chain();
    t_ecStart();
    t_zero();
    t_collide();
    t_abort();
    t_irq();
    t_busyWr();
    chk("R12 request held until ack", holdErr, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule